// File: doc/BRIEF.md
# Radio-State Driven GPIO Controller

This block drives a 32-bit general-purpose I/O bus whose output pattern can follow the radio's activity without software work at each switch. Software loads six 32-bit setup registers through a simple write port: one output pattern for each of the four radio states, a per-bit direction mask, and a per-bit static-mode mask. Two status lines from the radio, one for transmit and one for receive, select which pattern is driven.

Each bit is handled on its own. A bit in static mode always drives the idle pattern, whatever the radio does. A bit in automatic mode drives the pattern of the current radio state. The direction mask goes straight out as the per-bit output enable. A readback bus returns, bit by bit, either the value being driven (for outputs) or the pin input after a two-flop synchronizer (for inputs). The bus is often split into a receive-side half (bits 15:0) and a transmit-side half (bits 31:16), each set up on its own.

Top module: `radio_gpio_ctrl`

## Requirements
- R1: After reset all six setup registers are zero: pin_oe is 0, pin_out is 0 in every radio state, and rd_data returns the synchronized pin inputs.
- R2: The radio state is {tx_active, rx_active}: 00 idle, 01 receive only, 10 transmit only, 11 full duplex; for an automatic bit, pin_out takes the pattern written at byte offset 0, 4, 8 or 12 respectively.
- R3: A bit whose static-mode mask bit (offset 20) is 1 drives the idle pattern (offset 0) in every radio state; a 0 selects automatic mode.
- R4: pin_oe equals the direction mask written at offset 16; a 1 makes the bit an output.
- R5: For an output bit rd_data returns the value on pin_out; for an input bit it returns the synchronized pin_in value.
- R6: An input bit's readback follows pin_in two clock edges later.
- R7: A write with wr_en high is applied at that clock edge; a change on tx_active or rx_active appears on pin_out after the next clock edge, and not before it.
- R8: A write to any byte offset other than 0, 4, 8, 12, 16 or 20 changes no setup register.
- R9: Bits are independent, so the two 16-bit halves can carry different modes and directions at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the setup registers |
| wr_addr | input | 5 | Byte offset of the register written |
| wr_data | input | 32 | Write data |
| tx_active | input | 1 | Radio is transmitting |
| rx_active | input | 1 | Radio is receiving |
| pin_in | input | 32 | Pin input values |
| pin_oe | output | 32 | Per-bit output enable |
| pin_out | output | 32 | Per-bit output value |
| rd_data | output | 32 | Per-bit readback of the pin state |

## Verification
Distinct patterns are loaded into the four state registers so that every radio state yields a different output word, and all four states are stepped through with automatic, static and mixed per-bit modes; a wrong state decode or a wrong mode select then shows as a mismatch in specific bits. Direction masks that differ between the two halves separate the readback of driven values from the readback of pins, and a pin change is tracked edge by edge to pin down the synchronizer depth. Writes to undefined offsets with all-ones data follow a known setup, so any stray register update shows on the outputs.

// File: rtl/atrgpio_pkg.sv
package atrgpio_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'b00,
    RS_RX   = 2'b01,
    RS_TX   = 2'b10,
    RS_FDX  = 2'b11
  } radio_state_e;

  // Register bank index; byte offset is index times four.
  localparam int unsigned NUM_REGS  = 6;
  localparam int unsigned IX_IDLE   = 0;
  localparam int unsigned IX_RX     = 1;
  localparam int unsigned IX_TX     = 2;
  localparam int unsigned IX_FDX    = 3;
  localparam int unsigned IX_DIR    = 4;
  localparam int unsigned IX_STATIC = 5;
  localparam int unsigned REG_STRIDE = 4;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import atrgpio_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] idle_q,
  output logic [DW-1:0] rx_q,
  output logic [DW-1:0] tx_q,
  output logic [DW-1:0] fdx_q,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] static_q,
  output logic          wr_hit
);
  logic [NUM_REGS-1:0] hit_vec;
  logic [DW-1:0]       bank_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign hit_vec[i] = wr_en && (wr_addr == AW'(i * REG_STRIDE));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bank_q[i] <= '0;
      else if (hit_vec[i]) bank_q[i] <= wr_data;
    end
  end

  assign wr_hit   = |hit_vec;
  assign idle_q   = bank_q[IX_IDLE];
  assign rx_q     = bank_q[IX_RX];
  assign tx_q     = bank_q[IX_TX];
  assign fdx_q    = bank_q[IX_FDX];
  assign dir_q    = bank_q[IX_DIR];
  assign static_q = bank_q[IX_STATIC];

  // R8
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit) |=> ($stable(idle_q) && $stable(rx_q) && $stable(tx_q) &&
                            $stable(fdx_q) && $stable(dir_q) && $stable(static_q)));

  // R7
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(IX_DIR * REG_STRIDE)) |=> (dir_q == $past(wr_data)));
endmodule

// File: rtl/gpio_pattern_sel.sv
module gpio_pattern_sel
  import atrgpio_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_active,
  input  logic          rx_active,
  input  logic [DW-1:0] idle_q,
  input  logic [DW-1:0] rx_q,
  input  logic [DW-1:0] tx_q,
  input  logic [DW-1:0] fdx_q,
  input  logic [DW-1:0] static_q,
  output radio_state_e  state_q,
  output logic [DW-1:0] drive_val
);
  function automatic logic [DW-1:0] pick_pattern(
    radio_state_e s, logic [DW-1:0] p_idle, logic [DW-1:0] p_rx,
    logic [DW-1:0] p_tx, logic [DW-1:0] p_fdx);
    case (s)
      RS_RX:   return p_rx;
      RS_TX:   return p_tx;
      RS_FDX:  return p_fdx;
      default: return p_idle;
    endcase
  endfunction

  function automatic logic [DW-1:0] blend(
    logic [DW-1:0] stat, logic [DW-1:0] fixed_v, logic [DW-1:0] auto_v);
    return (stat & fixed_v) | (~stat & auto_v);
  endfunction

  logic [DW-1:0] auto_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RS_IDLE;
    else        state_q <= radio_state_e'({tx_active, rx_active});
  end

  assign auto_val  = pick_pattern(state_q, idle_q, rx_q, tx_q, fdx_q);
  assign drive_val = blend(static_q, idle_q, auto_val);
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int DW     = 32,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] sync_out
);
  logic [DW-1:0] stage_q [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[k] <= '0;
        else        stage_q[k] <= pin_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[k] <= '0;
        else        stage_q[k] <= stage_q[k-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/radio_gpio_ctrl.sv
module radio_gpio_ctrl
  import atrgpio_pkg::*;
#(
  parameter int DW          = 32,
  parameter int AW          = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          tx_active,
  input  logic          rx_active,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_oe,
  output logic [DW-1:0] pin_out,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] idle_q, rx_q, tx_q, fdx_q, dir_q, static_q;
  logic [DW-1:0] pin_sync;
  logic          wr_hit;
  radio_state_e  state_q;

  gpio_cfg_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .idle_q(idle_q), .rx_q(rx_q), .tx_q(tx_q), .fdx_q(fdx_q),
    .dir_q(dir_q), .static_q(static_q), .wr_hit(wr_hit)
  );

  gpio_pattern_sel #(.DW(DW)) u_sel (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .rx_active(rx_active),
    .idle_q(idle_q), .rx_q(rx_q), .tx_q(tx_q), .fdx_q(fdx_q),
    .static_q(static_q), .state_q(state_q), .drive_val(pin_out)
  );

  gpio_in_sync #(.DW(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sync_out(pin_sync)
  );

  assign pin_oe  = dir_q;
  assign rd_data = (dir_q & pin_out) | (~dir_q & pin_sync);

  // Cycles since reset, saturating, so history checks only look back as far as valid.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R3
  static_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q != 2'd0 && !$past(wr_en)) |-> (((pin_out ^ $past(pin_out)) & static_q) == '0));

  if (SYNC_STAGES == 2) begin : g_lag_chk
    // R6
    input_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q >= 2'd2) |-> ((rd_data & ~dir_q) == ($past(pin_in, 2) & ~dir_q)));
  end
endmodule

// File: tb/tb_radio_gpio_ctrl.sv
module tb_radio_gpio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        tx_active = 1'b0;
  logic        rx_active = 1'b0;
  logic [31:0] pin_in = 32'h5A5A_0F0F;
  logic [31:0] pin_oe, pin_out, rd_data;

  int checks = 0;
  int failures = 0;

  // Bench-side copy of what software has written.
  logic [31:0] m_pat [4];
  logic [31:0] m_dir = '0;
  logic [31:0] m_stat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  radio_gpio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_active(tx_active), .rx_active(rx_active), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .rd_data(rd_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected drive for state code st (tx,rx), walked bit by bit.
  function automatic logic [31:0] model_out(int st);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) begin
      r[b] = m_stat[b] ? m_pat[0][b] : m_pat[st][b];
    end
    return r;
  endfunction

  task automatic write_reg(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      5'd0:  m_pat[0] = d;
      5'd4:  m_pat[1] = d;
      5'd8:  m_pat[2] = d;
      5'd12: m_pat[3] = d;
      5'd16: m_dir = d;
      5'd20: m_stat = d;
      default: ;
    endcase
  endtask

  task automatic set_state(int st);
    @(negedge clk);
    tx_active = st[1]; rx_active = st[0];
    @(negedge clk);
  endtask

  task automatic load_patterns();
    write_reg(5'd0,  32'h1111_AAAA);
    write_reg(5'd4,  32'h2222_BBBB);
    write_reg(5'd8,  32'h4444_CCCC);
    write_reg(5'd12, 32'h8888_DDDD);
  endtask

  task automatic t_reset();
    check("R1 oe after reset", pin_oe, 32'h0);
    for (int st = 0; st < 4; st++) begin
      set_state(st);
      check("R1 out after reset", pin_out, 32'h0);
    end
    set_state(0);
    check("R1 readback of pins", rd_data, pin_in);
  endtask

  task automatic t_states();
    load_patterns();
    for (int st = 0; st < 4; st++) begin
      set_state(st);
      check("R2 state pattern", pin_out, model_out(st));
    end
    check("R2 fdx word", pin_out, 32'h8888_DDDD);
    set_state(1);
    check("R2 rx word", pin_out, 32'h2222_BBBB);
  endtask

  task automatic t_static();
    write_reg(5'd20, 32'hFFFF_FFFF);
    for (int st = 0; st < 4; st++) begin
      set_state(st);
      check("R3 all static drives idle", pin_out, 32'h1111_AAAA);
    end
    write_reg(5'd20, 32'h0F0F_00FF);
    for (int st = 0; st < 4; st++) begin
      set_state(st);
      check("R3 mixed static", pin_out, model_out(st));
    end
  endtask

  task automatic t_dir_readback();
    write_reg(5'd16, 32'hFFFF_0000);
    check("R4 oe follows direction", pin_oe, 32'hFFFF_0000);
    set_state(2);
    repeat (2) @(negedge clk);
    check("R5 readback mix", rd_data, (pin_out & 32'hFFFF_0000) | (pin_in & 32'h0000_FFFF));
    write_reg(5'd16, 32'h0000_FFFF);
    check("R9 halves swapped oe", pin_oe, 32'h0000_FFFF);
    check("R5 readback swapped", rd_data, (pin_out & 32'h0000_FFFF) | (pin_in & 32'hFFFF_0000));
  endtask

  task automatic t_halves();
    write_reg(5'd20, 32'h0000_FFFF);
    write_reg(5'd16, 32'hFFFF_FFFF);
    for (int st = 0; st < 4; st++) begin
      set_state(st);
      check("R9 low static high auto",
            pin_out, {m_pat[st][31:16], m_pat[0][15:0]});
    end
  endtask

  task automatic t_sync_lag();
    write_reg(5'd16, 32'h0);
    @(negedge clk);
    pin_in = 32'hC3C3_3C3C;
    @(negedge clk);
    check("R6 one edge later still old", rd_data, 32'h5A5A_0F0F);
    @(negedge clk);
    check("R6 two edges later new", rd_data, 32'hC3C3_3C3C);
  endtask

  task automatic t_timing();
    write_reg(5'd16, 32'hFFFF_FFFF);
    write_reg(5'd20, 32'h0);
    set_state(0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'h0BAD_F00D;
    #1 check("R7 write not before edge", pin_out, 32'h1111_AAAA);
    @(posedge clk); #1;
    check("R7 write at edge", pin_out, 32'h0BAD_F00D);
    @(negedge clk);
    wr_en = 1'b0; m_pat[0] = 32'h0BAD_F00D;
    tx_active = 1'b1; rx_active = 1'b1;
    #1 check("R7 state not before edge", pin_out, 32'h0BAD_F00D);
    @(posedge clk); #1;
    check("R7 state after edge", pin_out, 32'h8888_DDDD);
  endtask

  task automatic t_bad_offsets();
    write_reg(5'd20, 32'h00FF_00FF);
    write_reg(5'd16, 32'hF0F0_F0F0);
    write_reg(5'd2,  32'hFFFF_FFFF);
    write_reg(5'd24, 32'hFFFF_FFFF);
    write_reg(5'd28, 32'hFFFF_FFFF);
    write_reg(5'd31, 32'hFFFF_FFFF);
    write_reg(5'd13, 32'hFFFF_FFFF);
    check("R8 direction untouched", pin_oe, 32'hF0F0_F0F0);
    for (int st = 0; st < 4; st++) begin
      set_state(st);
      check("R8 outputs untouched", pin_out, model_out(st));
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_pat[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 readback zero in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    t_reset();
    t_states();
    t_static();
    t_dir_readback();
    t_halves();
    t_sync_lag();
    t_timing();
    t_bad_offsets();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule